// File: doc/BRIEF.md
# Sectored Write-Back Data Cache

This block is a small two-way set-associative data cache that sits between a processor port and a memory port. Every line is cut into word-sized sectors, and each sector has its own valid and dirty flag. A line can therefore be partly present: a store that misses claims a line and fills only the word it writes, with no fetch of the rest of the line. A load that finds its line but not its word fetches that one word and nothing else.

The processor issues one whole-word load or store per valid/ready handshake. Loads that hit return their data one cycle after acceptance. Misses stall the processor port while the controller works. When a line is replaced, the controller writes back only the dirty sectors, one word at a time over the memory handshake, and then reuses the way. Each set keeps one least-recently-used bit. An empty way is always taken before a used one.

Top module: `sector_cache`

## Requirements
- R1: After reset all sectors are invalid and clean and every LRU bit is cleared. `cpu_ready` is high, `cpu_rvalid` and `mem_valid` are low, and the first load of any address fetches from memory.
- R2: A load whose tag matches and whose sector is valid raises `cpu_rvalid` with the stored word in the first cycle after acceptance, with no memory transaction.
- R3: A load that matches the tag but finds its sector invalid issues exactly one memory read at the word address `{tag, set, sector, 2'b00}`. It returns that word, and the sector then holds it as valid and clean.
- R4: A store, hit or miss, updates the cached word and marks its sector dirty. It causes no memory write at the time of the store, and a dirty sector is always also valid.
- R5: A store that misses allocates a line without reading memory and makes only its own sector valid. A later load of another sector of that line must fetch.
- R6: Two addresses with the same set index and different tags can be resident together, and both hit. At most one way of a set matches a given tag.
- R7: When both ways of a set hold data, a tag miss replaces the least recently used way. Every hit and every allocation marks its way as most recently used. An empty way (all sectors invalid) is chosen first, with way 0 ahead of way 1.
- R8: Replacing a line writes back exactly its dirty sectors, in ascending sector order, to `{old tag, set, sector, 2'b00}`, before the new line's word is fetched. Clean sectors are not written.
- R9: Address bits [1:0] are ignored. The tag is bits [31:8], the set index bits [7:6] and the sector index bits [5:2].
- R10: `cpu_ready` stays low for as long as a miss fill or a write-back is in progress, so only one request is in flight.
- R11: Once `mem_valid` is raised, it stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_rvalid | output | 1 | Load data valid, one cycle wide |
| cpu_rdata | output | 32 | Load data |
| mem_valid | output | 1 | Memory transaction present |
| mem_ready | input | 1 | Memory accepts the transaction (read data valid) |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
A corrupted valid bit shows up on the next load of that sector. The load either returns a stale word with no memory read, or it fetches a word it should have hit. A lost dirty bit or a wrong LRU bit stays hidden until the set is next replaced. It then appears on the memory port as a missing or extra write-back, or as a write-back to the wrong tag. It appears again when the evicted word is read back and does not match what was stored. The stimulus therefore makes every replacement observable: it stores to words and forces their eviction, reads them back through memory, and checks the write-back log for both order and content.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  // one LRU bit per set fixes the associativity at two
  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    S_IDLE,   // accepting requests, hits finish here
    S_SCAN,   // step through victim sectors looking for dirty ones
    S_WB,     // one dirty sector on the memory port
    S_RETAG,  // install new tag, clear sector flags
    S_FILL    // fetch a single word
  } state_t;
endpackage

// File: rtl/sc_data_way.sv
`timescale 1ns/1ps
module sc_data_way #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sc_tag_store.sv
`timescale 1ns/1ps
module sc_tag_store
  import sc_pkg::*;
#(
  parameter int SETS    = 4,
  parameter int SECTORS = 16,
  parameter int TAG_W   = 24,
  localparam int SET_W  = $clog2(SETS),
  localparam int SEC_W  = $clog2(SECTORS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [SET_W-1:0]               lk_set,
  output logic [WAYS-1:0][TAG_W-1:0]     lk_tag,
  output logic [WAYS-1:0][SECTORS-1:0]   lk_valid,
  output logic [WAYS-1:0][SECTORS-1:0]   lk_dirty,
  output logic                           lk_lru,
  input  logic                           upd_en,
  input  logic                           upd_retag,
  input  logic [SET_W-1:0]               upd_set,
  input  logic                           upd_way,
  input  logic [TAG_W-1:0]               upd_tag,
  input  logic [SEC_W-1:0]               upd_sector,
  input  logic                           upd_valid,
  input  logic                           upd_dirty,
  input  logic                           upd_touch
);
  logic [TAG_W-1:0]   tag_r   [SETS][WAYS];
  logic [SECTORS-1:0] valid_r [SETS][WAYS];
  logic [SECTORS-1:0] dirty_r [SETS][WAYS];
  logic [SETS-1:0]    lru_r;   // index of the least recently used way

  logic [SECTORS-1:0] sec_bit;
  logic [SECTORS-1:0] base_v, base_d;

  assign sec_bit = SECTORS'(1) << upd_sector;
  assign base_v  = upd_retag ? {SECTORS{1'b0}} : valid_r[upd_set][upd_way];
  assign base_d  = upd_retag ? {SECTORS{1'b0}} : dirty_r[upd_set][upd_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      lru_r <= '0;
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tag_r[s][w]   <= '0;
          valid_r[s][w] <= '0;
          dirty_r[s][w] <= '0;
        end
      end
    end else if (upd_en) begin
      if (upd_retag) tag_r[upd_set][upd_way] <= upd_tag;
      valid_r[upd_set][upd_way] <= base_v | (upd_valid ? sec_bit : {SECTORS{1'b0}});
      dirty_r[upd_set][upd_way] <= base_d | (upd_dirty ? sec_bit : {SECTORS{1'b0}});
      if (upd_touch) lru_r[upd_set] <= ~upd_way;
    end
  end

  assign lk_lru = lru_r[lk_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_look
    assign lk_tag[w]   = tag_r[lk_set][w];
    assign lk_valid[w] = valid_r[lk_set][w];
    assign lk_dirty[w] = dirty_r[lk_set][w];
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk_s
    for (genvar w = 0; w < WAYS; w++) begin : g_chk_w
      AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (dirty_r[s][w] & ~valid_r[s][w]) == {SECTORS{1'b0}}); // R4
    end
  end
endmodule

// File: rtl/sector_cache.sv
`timescale 1ns/1ps
module sector_cache
  import sc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SETS    = 4,
  parameter int SECTORS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W  = 2;
  localparam int SET_W  = $clog2(SETS);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int TAG_W  = ADDR_W - SET_W - SEC_W - OFF_W;
  localparam int RAM_AW = SET_W + SEC_W;
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SECTORS - 1);

  // request fields
  logic [TAG_W-1:0] in_tag;
  logic [SET_W-1:0] in_set;
  logic [SEC_W-1:0] in_sec;
  logic             unused_off;
  assign in_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
  assign in_set     = cpu_addr[OFF_W+SEC_W +: SET_W];
  assign in_sec     = cpu_addr[OFF_W +: SEC_W];
  assign unused_off = ^cpu_addr[OFF_W-1:0];

  state_t           state_q;
  logic [TAG_W-1:0] tag_q;
  logic [SET_W-1:0] set_q;
  logic [SEC_W-1:0] sec_q, idx_q;
  logic             we_q, way_q, sel_fill_q, rvalid_q;
  logic [DATA_W-1:0] wdata_q, fill_q;

  // tag store interface
  logic [SET_W-1:0]             lk_set;
  logic [WAYS-1:0][TAG_W-1:0]   lk_tag;
  logic [WAYS-1:0][SECTORS-1:0] lk_valid, lk_dirty;
  logic                         lk_lru;
  logic                         upd_en, upd_retag, upd_way, upd_valid, upd_dirty, upd_touch;
  logic [SET_W-1:0]             upd_set;
  logic [SEC_W-1:0]             upd_sector;

  // data store interface
  logic [WAYS-1:0]   ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata;
  logic              ram_re;
  logic [DATA_W-1:0] rd_q [WAYS];

  assign cpu_ready = (state_q == S_IDLE);
  assign lk_set    = cpu_ready ? in_set : set_q;

  logic accept;
  assign accept = cpu_valid && cpu_ready;

  sc_tag_store #(.SETS(SETS), .SECTORS(SECTORS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst, .lk_set, .lk_tag, .lk_valid, .lk_dirty, .lk_lru,
    .upd_en, .upd_retag, .upd_set, .upd_way, .upd_tag(tag_q),
    .upd_sector, .upd_valid, .upd_dirty, .upd_touch
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    sc_data_way #(.DW(DATA_W), .AW(RAM_AW)) u_data (
      .clk, .we(ram_we[w]), .waddr(ram_waddr), .wdata(ram_wdata),
      .re(ram_re), .raddr(ram_raddr), .rdata(rd_q[w])
    );
  end

  // lookup
  logic [WAYS-1:0] tag_hit, line_live;
  logic            hit_way, any_hit, rd_hit, victim;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign line_live[w] = |lk_valid[w];
    assign tag_hit[w]   = line_live[w] && (lk_tag[w] == in_tag);
  end
  assign hit_way = tag_hit[1];
  assign any_hit = |tag_hit;
  assign rd_hit  = any_hit && lk_valid[hit_way][in_sec];
  assign victim  = !line_live[0] ? 1'b0 : (!line_live[1] ? 1'b1 : lk_lru);

  always_comb begin
    upd_en = 1'b0; upd_retag = 1'b0; upd_set = set_q; upd_way = way_q;
    upd_sector = sec_q; upd_valid = 1'b0; upd_dirty = 1'b0; upd_touch = 1'b0;
    ram_we = '0; ram_waddr = {set_q, sec_q}; ram_wdata = wdata_q;
    ram_re = 1'b0; ram_raddr = {set_q, idx_q};
    mem_valid = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = rd_q[way_q];
    case (state_q)
      S_IDLE: if (accept) begin
        upd_set = in_set; upd_way = hit_way; upd_sector = in_sec;
        ram_waddr = {in_set, in_sec}; ram_raddr = {in_set, in_sec};
        if (cpu_we && any_hit) begin
          upd_en = 1'b1; upd_valid = 1'b1; upd_dirty = 1'b1; upd_touch = 1'b1;
          ram_we[hit_way] = 1'b1; ram_wdata = cpu_wdata;
        end else if (!cpu_we && rd_hit) begin
          upd_en = 1'b1; upd_touch = 1'b1; ram_re = 1'b1;
        end
      end
      S_SCAN: ram_re = lk_dirty[way_q][idx_q];
      S_WB: begin
        mem_valid = 1'b1; mem_we = 1'b1;
        mem_addr  = {lk_tag[way_q], set_q, idx_q, 2'b00};
      end
      S_RETAG: begin
        upd_en = 1'b1; upd_retag = 1'b1;
        upd_valid = we_q; upd_dirty = we_q; upd_touch = we_q;
        ram_we[way_q] = we_q;
      end
      S_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {tag_q, set_q, sec_q, 2'b00};
        if (mem_ready) begin
          upd_en = 1'b1; upd_valid = 1'b1; upd_touch = 1'b1;
          ram_we[way_q] = 1'b1; ram_wdata = mem_rdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE; tag_q <= '0; set_q <= '0; sec_q <= '0; idx_q <= '0;
      we_q <= 1'b0; way_q <= 1'b0; sel_fill_q <= 1'b0; rvalid_q <= 1'b0;
      wdata_q <= '0; fill_q <= '0;
    end else begin
      rvalid_q <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          tag_q <= in_tag; set_q <= in_set; sec_q <= in_sec;
          we_q <= cpu_we; wdata_q <= cpu_wdata; idx_q <= '0;
          if (cpu_we) begin
            if (!any_hit) begin way_q <= victim; state_q <= S_SCAN; end
          end else if (rd_hit) begin
            way_q <= hit_way; sel_fill_q <= 1'b0; rvalid_q <= 1'b1;
          end else if (any_hit) begin
            way_q <= hit_way; state_q <= S_FILL;
          end else begin
            way_q <= victim; state_q <= S_SCAN;
          end
        end
        S_SCAN:
          if (lk_dirty[way_q][idx_q])  state_q <= S_WB;
          else if (idx_q == LAST_SEC)  state_q <= S_RETAG;
          else                         idx_q   <= idx_q + 1'b1;
        S_WB: if (mem_ready) begin
          if (idx_q == LAST_SEC) state_q <= S_RETAG;
          else begin idx_q <= idx_q + 1'b1; state_q <= S_SCAN; end
        end
        S_RETAG: state_q <= we_q ? S_IDLE : S_FILL;
        S_FILL: if (mem_ready) begin
          fill_q <= mem_rdata; sel_fill_q <= 1'b1; rvalid_q <= 1'b1; state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = sel_fill_q ? fill_q : rd_q[way_q];

  AST_HIT_RVALID: assert property (@(posedge clk) disable iff (rst)
    (accept && !cpu_we && rd_hit) |=> cpu_rvalid); // R2
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !cpu_ready); // R10
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(tag_hit) <= 1); // R6
endmodule

// File: tb/sector_cache_bench.sv
`timescale 1ns/1ps
module sector_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;   // 250 MHz

  sector_cache u_sector_cache (
    .clk, .rst, .cpu_valid, .cpu_ready, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_rvalid, .cpu_rdata, .mem_valid, .mem_ready, .mem_we, .mem_addr,
    .mem_wdata, .mem_rdata
  );

  int n_chk = 0, n_err = 0;
  int n_rd = 0, n_wr = 0, wl_n = 0;
  logic [31:0] wlog_a [16];
  logic [31:0] wlog_d [16];
  logic [31:0] mem_model [logic [31:0]];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000 ^ {a[15:0], 16'h0000};
  endfunction

  // memory: one wait cycle, then ready; transaction recorded when ready is raised
  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_valid) begin
      if (mem_we) begin
        mem_model[mem_addr] = mem_wdata;
        if (wl_n < 16) begin wlog_a[wl_n] = mem_addr; wlog_d[wl_n] = mem_wdata; end
        wl_n++; n_wr++;
      end else begin
        n_rd++;
        mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : pat(mem_addr);
      end
      mem_ready = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int lat, output bit busy_bad);
    bit acc;
    busy_bad = 1'b0; lat = 0; acc = 1'b0;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!acc) begin acc = cpu_ready; @(negedge clk); end
    cpu_valid = 1'b0;
    while (we ? !cpu_ready : !cpu_rvalid) begin
      if (cpu_ready) busy_bad = 1'b1;
      lat++;
      @(negedge clk);
      if (lat > 2000) break;
    end
    rd = cpu_rdata;
  endtask

  // set 1; tags 1 (A), 2 (B), 3 (C): addr = tag<<8 | set<<6 | sector<<2
  localparam int NV = 14;
  localparam bit          V_WE  [NV] = '{1,0,0,0,0,0,0,0,1,1,0,0,0,0};
  localparam logic [31:0] V_AD  [NV] = '{32'h14C, 32'h14C, 32'h154, 32'h154, 32'h240, 32'h14C, 32'h348,
                                         32'h14C, 32'h35C, 32'h344, 32'h240, 32'h14C, 32'h35C, 32'h35F};
  localparam logic [31:0] V_WD  [NV] = '{32'h1111_0003, 0, 0, 0, 0, 0, 0, 0, 32'h2222_0007, 32'h2222_0001, 0, 0, 0, 0};
  // expected load data; 0 means "memory pattern of this address"
  localparam logic [31:0] V_EXP [NV] = '{0, 32'h1111_0003, 0, 0, 0, 32'h1111_0003, 0, 32'h1111_0003,
                                         0, 0, 0, 32'h1111_0003, 32'h2222_0007, 32'h2222_0007};
  localparam int V_RD  [NV] = '{0,0,1,0,1,0,1,0,0,0,1,1,1,0};
  localparam int V_WRB [NV] = '{0,0,0,0,0,0,0,0,0,0,1,2,0,0};
  // 0 R5 alloc no fetch, 1 R2 hit, 2 R3/R5 sector fetch, 3 R2, 4 R6 second way, 5 R6 coexist,
  // 6 R7 LRU victim B (clean), 7 R7 A kept, 8-9 R4 store hits, 10-12 R8 dirty write-back, 13 R9 offset
  localparam int V_REQ [NV] = '{5,2,3,2,6,6,7,7,4,4,8,8,8,9};

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    int lat, r0, w0;
    bit bb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ready", {31'b0, cpu_ready}, 32'd1);
    chk("R1 rvalid", {31'b0, cpu_rvalid}, 32'd0);
    chk("R1 mem_valid", {31'b0, mem_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", V_REQ[i], i);
      r0 = n_rd; w0 = n_wr;
      do_op(V_WE[i], V_AD[i], V_WD[i], rd, lat, bb);
      if (!V_WE[i]) chk({tg, " data"}, rd, (V_EXP[i] == 0) ? pat(V_AD[i]) : V_EXP[i]);
      chk({tg, " mem reads"}, n_rd - r0, V_RD[i]);
      chk({tg, " mem writes"}, n_wr - w0, V_WRB[i]);
      if (!V_WE[i] && V_RD[i] == 0) chk({tg, " R2 latency"}, lat, 0);
      chk({tg, " R10 busy"}, {31'b0, bb}, 32'd0);
    end

    // R8 write-back content and ascending order
    chk("R8 wb count", wl_n, 3);
    chk("R8 wb0 addr", wlog_a[0], 32'h14C);
    chk("R8 wb0 data", wlog_d[0], 32'h1111_0003);
    chk("R8 wb1 addr", wlog_a[1], 32'h344);
    chk("R8 wb1 data", wlog_d[1], 32'h2222_0001);
    chk("R8 wb2 addr", wlog_a[2], 32'h35C);
    chk("R8 wb2 data", wlog_d[2], 32'h2222_0007);

    // R1: reset invalidates a resident line
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 ready after 2nd reset", {31'b0, cpu_ready}, 32'd1);
    r0 = n_rd; w0 = n_wr;
    do_op(1'b0, 32'h35C, 0, rd, lat, bb);
    chk("R1 refetch data", rd, 32'h2222_0007);
    chk("R1 refetch reads", n_rd - r0, 1);
    chk("R1 no write-back", n_wr - w0, 0);

    // R9 store with nonzero byte offset lands on the same word
    r0 = n_rd; w0 = n_wr;
    do_op(1'b1, 32'h35D, 32'h3333_0007, rd, lat, bb);
    do_op(1'b0, 32'h35C, 0, rd, lat, bb);
    chk("R9 offset store data", rd, 32'h3333_0007);
    chk("R9 R4 no traffic", (n_rd - r0) + (n_wr - w0), 0);

    // R3 tag hit, invalid sector: one read, then a hit
    r0 = n_rd;
    do_op(1'b0, 32'h370, 0, rd, lat, bb);
    chk("R3 fill data", rd, pat(32'h370));
    chk("R3 one read", n_rd - r0, 1);
    do_op(1'b0, 32'h370, 0, rd, lat, bb);
    chk("R3 now valid", n_rd - r0, 1);
    summary();
  end
endmodule